// File: doc/BRIEF.md
# Bipolar Avionics Word Receiver

This block takes a bipolar return-to-zero avionics serial line, presented as two digital legs (a high leg and a low leg), and rebuilds 32-bit words from it. The line is sampled about ten times per bit. The sample strobe runs either at every master-clock cycle or at every eighth cycle, so one design serves both the fast and the slow line speed. Each bit cell is checked for its total length, its active-pulse length and its return-to-null length. A word is kept only when it has exactly 32 well-formed bits and is followed by a long enough quiet gap.

Before a word is stored, its most significant bit is replaced by the outcome of an odd-parity test over all 32 received bits. A host then reads the stored word through a 16-bit port in two halves, low half first. A ready flag shows that a word is waiting. Reading the high half clears the flag. If a new word is accepted in the same cycle as that read, the new word replaces the old one and the flag stays set.

Top module: `a429_rx`

## Requirements
- R1: After reset, `data_ready` is 0 and `rd_data` is 0 for both values of `rd_hi`.
- R2: With `rate_sel` = 0 the line legs are sampled on every clock. With `rate_sel` = 1 they are sampled once every 8 clocks. A word sent at the fast timing while the slow rate is selected is dropped.
- R3: A sample with only `line_hi` set is an active 1 and a sample with only `line_lo` set is an active 0. The first bit on the line lands in word bit 0, and each later bit lands one position higher.
- R4: The period from one pulse start to the next pulse start must be 8 to 12 samples inclusive, or the word is dropped.
- R5: Each active pulse must last 3 to 7 samples, and the null before the next pulse must last at least 3 samples, or the word is dropped.
- R6: A sample with both legs set, or a change of leg with no null sample between, drops the word.
- R7: A word is accepted on its 30th consecutive null sample only if exactly 32 pulses came before it. A 33rd pulse drops the word, and so does a gap that ends a shorter word. No word starts until 30 null samples have been seen after reset or after an error.
- R8: Stored bit 31 is 0 when the 32 received bits hold an odd number of ones and 1 otherwise. Stored bits 30..0 are the received bits.
- R9: `rd_data` shows stored bits 15..0 when `rd_hi` = 0 and bits 31..16 when `rd_hi` = 1, with no clock delay. The stored word changes only when a word is accepted.
- R10: `data_ready` rises in the clock after acceptance. A cycle with `rd_en` = 1 and `rd_hi` = 1 clears it. An acceptance in that same cycle wins: the new word is stored and `data_ready` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock (nominally 1 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 1 | 0: sample every clock; 1: sample every 8 clocks |
| line_hi | input | 1 | High leg of the line, active high |
| line_lo | input | 1 | Low leg of the line, active high |
| rd_en | input | 1 | Host read strobe |
| rd_hi | input | 1 | Half select: 0 low half, 1 high half |
| rd_data | output | 16 | Selected half of the stored word |
| data_ready | output | 1 | A stored word is waiting to be read |

## Verification
Two events can fall in the same cycle: accepting a new word and the host's high-half read that clears the ready flag. The bench leaves one word unread, sends a second word, and raises the high-half read on exactly the cycle that carries the 30th null sample after the last pulse. It first confirms that the old word is still shown one sample earlier. It then requires that the flag is still set and that both halves show the second word, and that a later plain read clears the flag.

// File: rtl/a429_rx_pkg.sv
package a429_rx_pkg;
    localparam int WORD_W = 32;
    localparam int HALF_W = WORD_W / 2;
    typedef logic [WORD_W-1:0] rx_word_t;
    typedef logic [HALF_W-1:0] rx_half_t;
endpackage

// File: rtl/a429_rx_tick.sv
module a429_rx_tick #(
    parameter int SLOW_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rate_sel,
    output logic tick
);
    localparam int DW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(SLOW_DIV - 1);

    logic [DW-1:0] div_d, div_q;

    always_comb begin
        div_d = (div_q == LAST) ? '0 : div_q + 1'b1;
        tick  = rate_sel ? (div_q == LAST) : 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    AST_SLOW_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel && tick) |=> (!tick || !rate_sel)); // R2
endmodule

// File: rtl/a429_rx_frame.sv
module a429_rx_frame
    import a429_rx_pkg::*;
#(
    parameter int GAP      = 30,
    parameter int PER_MIN  = 8,
    parameter int PER_MAX  = 12,
    parameter int ACT_MIN  = 3,
    parameter int ACT_MAX  = 7,
    parameter int NULL_MIN = 3
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick,
    input  logic     line_hi,
    input  logic     line_lo,
    output logic     word_vld,
    output rx_word_t word_dat
);
    localparam int CNT_TOP = ((GAP > PER_MAX) ? GAP : PER_MAX) + 1;
    localparam int CW      = $clog2(CNT_TOP + 1);
    localparam int BCW     = $clog2(WORD_W + 1);
    localparam logic [CW-1:0]  GAP_C   = CW'(GAP);
    localparam logic [CW-1:0]  GAP_M1  = CW'(GAP - 1);
    localparam logic [CW-1:0]  PMIN_C  = CW'(PER_MIN);
    localparam logic [CW-1:0]  PMAX_C  = CW'(PER_MAX);
    localparam logic [CW-1:0]  AMIN_C  = CW'(ACT_MIN);
    localparam logic [CW-1:0]  AMAX_C  = CW'(ACT_MAX);
    localparam logic [CW-1:0]  NMIN_C  = CW'(NULL_MIN);
    localparam logic [BCW-1:0] FULL_C  = BCW'(WORD_W);

    typedef struct packed {
        logic           armed;
        logic           prev_act;
        logic           prev_bit;
        logic [BCW-1:0] bit_cnt;
        logic [CW-1:0]  per_cnt;
        logic [CW-1:0]  act_cnt;
        logic [CW-1:0]  null_cnt;
        rx_word_t       shreg;
    } frame_t;

    frame_t st_d, st_q;
    logic   act_s;

    function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v);
        return (v == '1) ? v : v + 1'b1;
    endfunction

    assign act_s = line_hi | line_lo;

    always_comb begin
        st_d     = st_q;
        word_vld = 1'b0;
        word_dat = {~^st_q.shreg, st_q.shreg[WORD_W-2:0]};
        if (tick) begin
            if (line_hi && line_lo) begin
                st_d.armed = 1'b0; st_d.bit_cnt = '0; st_d.null_cnt = '0;
            end else if (act_s) begin
                st_d.null_cnt = '0;
                if (!st_q.prev_act) begin
                    if (st_q.armed) begin
                        if (st_q.bit_cnt != '0 &&
                            (st_q.bit_cnt == FULL_C || st_q.per_cnt < PMIN_C ||
                             st_q.per_cnt > PMAX_C || st_q.null_cnt < NMIN_C)) begin
                            st_d.armed = 1'b0; st_d.bit_cnt = '0;
                        end else begin
                            st_d.bit_cnt = st_q.bit_cnt + 1'b1;
                            st_d.shreg   = {line_hi, st_q.shreg[WORD_W-1:1]};
                            st_d.per_cnt = CW'(1);
                            st_d.act_cnt = CW'(1);
                        end
                    end
                end else if (line_hi != st_q.prev_bit) begin
                    st_d.armed = 1'b0; st_d.bit_cnt = '0;
                end else begin
                    st_d.act_cnt = sat_inc(st_q.act_cnt);
                    st_d.per_cnt = sat_inc(st_q.per_cnt);
                end
            end else begin
                if (st_q.prev_act && st_q.armed && st_q.bit_cnt != '0 &&
                    (st_q.act_cnt < AMIN_C || st_q.act_cnt > AMAX_C)) begin
                    st_d.armed = 1'b0; st_d.bit_cnt = '0; st_d.null_cnt = '0;
                end else begin
                    st_d.per_cnt  = sat_inc(st_q.per_cnt);
                    st_d.null_cnt = (st_q.null_cnt == GAP_C) ? GAP_C : st_q.null_cnt + 1'b1;
                    if (st_q.null_cnt == GAP_M1) begin
                        st_d.armed   = 1'b1;
                        st_d.bit_cnt = '0;
                        word_vld     = st_q.armed && (st_q.bit_cnt == FULL_C);
                    end
                end
            end
            st_d.prev_act = act_s;
            st_d.prev_bit = line_hi;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_ACCEPT_ON_NULL: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |-> (tick && !line_hi && !line_lo)); // R7
    AST_ACCEPT_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |=> !word_vld); // R7
    AST_BITCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.bit_cnt <= FULL_C); // R7
endmodule

// File: rtl/a429_rx_hold.sv
module a429_rx_hold
    import a429_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     word_vld,
    input  rx_word_t word_dat,
    input  logic     rd_en,
    input  logic     rd_hi,
    output rx_half_t rd_data,
    output logic     data_ready
);
    typedef struct packed {
        rx_word_t word;
        logic     ready;
    } hold_t;

    hold_t hd_d, hd_q;

    always_comb begin
        hd_d = hd_q;
        if (word_vld) begin
            hd_d.word  = word_dat;
            hd_d.ready = 1'b1;
        end else if (rd_en && rd_hi) begin
            hd_d.ready = 1'b0;
        end
        rd_data    = rd_hi ? hd_q.word[WORD_W-1:HALF_W] : hd_q.word[HALF_W-1:0];
        data_ready = hd_q.ready;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hd_q <= '0;
        else        hd_q <= hd_d;
    end

    AST_READY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |=> data_ready); // R10
    AST_READY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (data_ready && rd_en && rd_hi && !word_vld) |=> !data_ready); // R10
    AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !word_vld |=> $stable(hd_q.word)); // R9
endmodule

// File: rtl/a429_rx.sv
module a429_rx
    import a429_rx_pkg::*;
#(
    parameter int SLOW_DIV = 8,
    parameter int GAP      = 30,
    parameter int PER_MIN  = 8,
    parameter int PER_MAX  = 12,
    parameter int ACT_MIN  = 3,
    parameter int ACT_MAX  = 7,
    parameter int NULL_MIN = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rate_sel,
    input  logic        line_hi,
    input  logic        line_lo,
    input  logic        rd_en,
    input  logic        rd_hi,
    output logic [15:0] rd_data,
    output logic        data_ready
);
    logic     tick;
    logic     word_vld;
    rx_word_t word_dat;

    a429_rx_tick #(.SLOW_DIV(SLOW_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .tick(tick)
    );

    a429_rx_frame #(
        .GAP(GAP), .PER_MIN(PER_MIN), .PER_MAX(PER_MAX),
        .ACT_MIN(ACT_MIN), .ACT_MAX(ACT_MAX), .NULL_MIN(NULL_MIN)
    ) u_frame (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .line_hi(line_hi), .line_lo(line_lo),
        .word_vld(word_vld), .word_dat(word_dat)
    );

    a429_rx_hold u_hold (
        .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .word_dat(word_dat),
        .rd_en(rd_en), .rd_hi(rd_hi), .rd_data(rd_data), .data_ready(data_ready)
    );
endmodule

// File: tb/tb_a429_rx.sv
module tb_a429_rx;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n, rate_sel, line_hi, line_lo, rd_en, rd_hi;
    logic [15:0] rd_data;
    logic data_ready;

    int n_cmp = 0;
    int n_bad = 0;
    int spb = 1;
    bit auto_rd = 1'b1;
    bit done = 1'b0;
    logic [31:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    a429_rx dut (
        .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .line_hi(line_hi),
        .line_lo(line_lo), .rd_en(rd_en), .rd_hi(rd_hi),
        .rd_data(rd_data), .data_ready(data_ready)
    );

    function automatic logic [31:0] exp_of(input logic [31:0] w);
        return {~^w, w[30:0]};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic smp(input logic h, input logic l);
        repeat (spb) begin
            @(negedge clk);
            line_hi = h;
            line_lo = l;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) smp(1'b0, 1'b0);
    endtask

    task automatic send_word(input logic [31:0] w, input int act_n, input int nul_n,
                             input int nbits, input int bad_idx, input bit push);
        if (push) exp_q.push_back(exp_of(w));
        for (int i = 0; i < nbits; i++) begin
            logic b;
            b = (i < 32) ? w[i] : 1'b1;
            if (i == bad_idx) repeat (act_n) smp(1'b1, 1'b1);
            else              repeat (act_n) smp(b, ~b);
            repeat (nul_n) smp(1'b0, 1'b0);
        end
        idle(40);
    endtask

    task automatic expect_drop(input string tag);
        #1;
        chk(data_ready == 1'b0, tag, {31'd0, data_ready}, 32'd0);
    endtask

    // Monitor: pops an expected word each time the design offers one.
    initial begin
        forever begin
            @(negedge clk);
            if (auto_rd && data_ready) begin
                logic [15:0] lo_h, hi_h;
                logic [31:0] got, e;
                rd_en = 1'b1; rd_hi = 1'b0;
                #1 lo_h = rd_data;
                @(negedge clk);
                rd_hi = 1'b1;
                #1 hi_h = rd_data;
                @(negedge clk);
                rd_en = 1'b0; rd_hi = 1'b0;
                got = {hi_h, lo_h};
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7 unexpected word accepted", got, 32'd0);
                end else begin
                    e = exp_q.pop_front();
                    chk(got == e, "R3 R8 R9 word content", got, e);
                end
                #1 chk(data_ready == 1'b0, "R10 ready cleared by high read", {31'd0, data_ready}, 32'd0);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired got=running exp=finished");
        summary();
    end

    initial begin
        logic [31:0] wa, wb, ea, eb;
        rst_n = 1'b0; rate_sel = 1'b0; line_hi = 1'b0; line_lo = 1'b0;
        rd_en = 1'b0; rd_hi = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk(data_ready == 1'b0, "R1 ready after reset", {31'd0, data_ready}, 32'd0);
        chk(rd_data == 16'd0, "R1 low half after reset", {16'd0, rd_data}, 32'd0);
        rd_hi = 1'b1;
        #1 chk(rd_data == 16'd0, "R1 high half after reset", {16'd0, rd_data}, 32'd0);
        rd_hi = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        idle(40);

        // R3 R8: nominal timing, odd and even parity patterns
        send_word(32'h0000_0001, 5, 5, 32, -1, 1'b1);
        send_word(32'h0000_0003, 5, 5, 32, -1, 1'b1);
        send_word(32'hC5A3_0F69, 5, 5, 32, -1, 1'b1);

        // R4: period boundaries
        send_word(32'h1357_9BDF, 4, 4, 32, -1, 1'b1);
        send_word(32'h2468_ACE0, 6, 6, 32, -1, 1'b1);
        send_word(32'h1111_2222, 4, 3, 32, -1, 1'b0);
        expect_drop("R4 period 7 dropped");
        send_word(32'h3333_4444, 6, 7, 32, -1, 1'b0);
        expect_drop("R4 period 13 dropped");

        // R5: pulse and null lengths
        send_word(32'h5555_6666, 2, 8, 32, -1, 1'b0);
        expect_drop("R5 short pulse dropped");
        send_word(32'h7777_8888, 8, 3, 32, -1, 1'b0);
        expect_drop("R5 long pulse dropped");
        send_word(32'h9999_AAAA, 7, 2, 32, -1, 1'b0);
        expect_drop("R5 short null dropped");

        // R6: both legs active
        send_word(32'hBBBB_CCCC, 5, 5, 32, 10, 1'b0);
        expect_drop("R6 both legs dropped");

        // R7: bit count
        send_word(32'hDDDD_EEEE, 5, 5, 31, -1, 1'b0);
        expect_drop("R7 31 bits dropped");
        send_word(32'h0F0F_F0F0, 5, 5, 33, -1, 1'b0);
        expect_drop("R7 33 bits dropped");

        // R2: slow sampling
        rate_sel = 1'b1;
        spb = 8;
        idle(40);
        send_word(32'hA5A5_5A5B, 5, 5, 32, -1, 1'b1);
        spb = 1;
        send_word(32'h0123_4567, 5, 5, 32, -1, 1'b0);
        idle(400);
        expect_drop("R2 fast word at slow rate dropped");
        rate_sel = 1'b0;
        idle(40);

        // R10: acceptance and high read in the same cycle
        auto_rd = 1'b0;
        wa = 32'h6B2D_91E4;
        wb = 32'h1C3E_5A77;
        ea = exp_of(wa);
        eb = exp_of(wb);
        send_word(wa, 5, 5, 32, -1, 1'b0);
        #1 chk(data_ready == 1'b1, "R10 first word pending", {31'd0, data_ready}, 32'd1);
        for (int i = 0; i < 32; i++) begin
            repeat (5) smp(wb[i], ~wb[i]);
            if (i < 31) repeat (5) smp(1'b0, 1'b0);
        end
        for (int k = 1; k <= 30; k++) begin
            @(negedge clk);
            line_hi = 1'b0; line_lo = 1'b0;
            if (k == 30) begin rd_en = 1'b1; rd_hi = 1'b1; end
            if (k == 29) begin
                #1 chk(rd_data == ea[15:0], "R7 no acceptance before 30th null", {16'd0, rd_data}, {16'd0, ea[15:0]});
            end
        end
        @(negedge clk);
        rd_en = 1'b0; rd_hi = 1'b0;
        #1 chk(data_ready == 1'b1, "R10 acceptance wins over clear", {31'd0, data_ready}, 32'd1);
        chk(rd_data == eb[15:0], "R9 R10 new low half", {16'd0, rd_data}, {16'd0, eb[15:0]});
        rd_hi = 1'b1;
        #1 chk(rd_data == eb[31:16], "R9 R10 new high half", {16'd0, rd_data}, {16'd0, eb[31:16]});
        @(negedge clk);
        rd_en = 1'b1; rd_hi = 1'b1;
        @(negedge clk);
        rd_en = 1'b0; rd_hi = 1'b0;
        #1 chk(data_ready == 1'b0, "R10 plain high read clears", {31'd0, data_ready}, 32'd0);
        auto_rd = 1'b1;
        idle(40);

        chk(exp_q.size() == 0, "R7 all expected words delivered", exp_q.size(), 32'd0);
        summary();
    end
endmodule